// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This unit performs the 8-bit arithmetic and logic work of an accumulator-style processor and keeps the six status flags that those operations produce. One operand is the accumulator (`opnd_a`), the other is a source operand (`opnd_b`). A 4-bit operation code picks the function. The result and the proposed next flag values (`flags_nxt`) appear combinationally in the same cycle. The flags are computed from the operands and from the flags currently held in the internal register (`flags_q`).

The flag register loads `flags_nxt` on a rising clock edge when `flag_we` is high. When `flag_we` is low it holds its value. The unit has no back-pressure: it accepts a new operation every cycle, and `flag_we` acts as the valid strobe of the flag path. Instruction decode, 16-bit arithmetic, shifts, rotates and decimal adjust belong to other blocks.

Top module: `alu8_flags`

## Requirements
- R1: Add (op 0) and add-with-carry (op 1) return `opnd_a + opnd_b`, plus the held carry flag for op 1.
  - Carry is set on a carry out of bit 7, and half-carry on a carry out of bit 3.
  - The parity/overflow flag is set on signed overflow, and the subtract flag is cleared.
- R2: Subtract (op 2) and subtract-with-carry (op 3) return `opnd_a - opnd_b`, minus the held carry flag for op 3.
  - Carry is set on a borrow into bit 7, and half-carry on a borrow from bit 4.
  - The parity/overflow flag is set on signed overflow, and the subtract flag is set.
- R3: Compare (op 4) produces the same flags as subtract and returns `opnd_a` unchanged as the result.
- R4: Negate (op 5) returns `0 - opnd_a`, with flags formed as for a subtraction of `opnd_a` from zero.
- R5: AND (op 6), OR (op 7) and XOR (op 8) return the bitwise result.
  - The parity/overflow flag is 1 when the result has an even count of ones.
  - Carry and the subtract flag are cleared.
  - Half-carry is set for AND and cleared for OR and XOR.
- R6: Increment (op 9) and decrement (op 10) act on `opnd_a`.
  - Half-carry and overflow are set as for adding or subtracting one.
  - The subtract flag is cleared by increment and set by decrement.
  - Carry keeps its held value.
- R7: For ops 0 to 10, the zero flag is set exactly when the 8-bit arithmetic or logic result is zero, and the sign flag equals bit 7 of that result.
- R8: Complement (op 11) returns `~opnd_a` and sets half-carry and the subtract flag. The other four flags keep their held values.
- R9: Set-carry (op 12) forces carry to 1, and complement-carry (op 13) inverts the held carry.
  - Both clear the subtract flag, keep the other four flags, and return `opnd_a`.
- R10: The flag register loads `flags_nxt` at a clock edge when `flag_we` is 1, and otherwise holds its value.
  - It resets asynchronously to all zeros.
  - Flag bit positions: 0 carry, 1 subtract, 2 parity/overflow, 3 half-carry, 4 zero, 5 sign.
- R11: The unused codes 14 and 15 return `opnd_a` and leave all flags at their held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Source operand |
| flag_we | input | 1 | Flag register load strobe |
| result | output | 8 | Operation result |
| flags_nxt | output | 6 | Next flag values |
| flags_q | output | 6 | Held flag register |

## Verification
The assertions assume that `op_sel`, the operands and `flag_we` are known values that settle between clock edges. Under that assumption, each cycle's combinational flags relate cleanly to the register contents at the following edge. The stimulus changes every input only on the falling edge and draws operation codes from the full 4-bit range, including the spare codes. `flag_we` is drawn at random, so both the load and the hold path of the register are exercised with live data.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_CMP = 4'd4,  OP_NEG = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
    OP_XOR = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_CPL = 4'd11,
    OP_SCF = 4'd12, OP_CCF = 4'd13, OP_RS0 = 4'd14, OP_RS1 = 4'd15
  } alu_op_e;

  localparam int NFLAG = 6;
  localparam int FC = 0;  // carry
  localparam int FN = 1;  // subtract indicator
  localparam int FP = 2;  // parity / overflow
  localparam int FH = 3;  // half carry
  localparam int FZ = 4;  // zero
  localparam int FS = 5;  // sign

  typedef logic [NFLAG-1:0] flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cy,
  output logic         hc,
  output logic         ov
);
  localparam int HB = W / 2;

  logic [W-1:0] y_e;
  logic         c_e;
  logic [W:0]   full;
  logic [HB:0]  low;

  always_comb begin
    y_e  = sub ? ~y : y;
    c_e  = sub ? ~cin : cin;
    full = {1'b0, x} + {1'b0, y_e} + {{W{1'b0}}, c_e};
    low  = {1'b0, x[HB-1:0]} + {1'b0, y_e[HB-1:0]} + {{HB{1'b0}}, c_e};
    r    = full[W-1:0];
    cy   = full[W] ^ sub;
    hc   = low[HB] ^ sub;
    ov   = (x[W-1] == y_e[W-1]) && (full[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [1:0]   fn,
  output logic [W-1:0] r,
  output logic         even
);
  always_comb begin
    case (fn)
      2'd0:    r = x & y;
      2'd1:    r = x | y;
      default: r = x ^ y;
    endcase
    even = ~(^r);
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NF-1:0] d,
  output logic [NF-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_sel,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic             flag_we,
  output logic [W-1:0]     result,
  output logic [NFLAG-1:0] flags_nxt,
  output logic [NFLAG-1:0] flags_q
);
  logic [W-1:0] ax, ay, ar, lr;
  logic         asub, acin, acy, ahc, aov, leven;
  logic [1:0]   lfn;
  flags_t       nf;

  // Route operands into the shared adder for each arithmetic operation.
  always_comb begin
    ax   = opnd_a;
    ay   = opnd_b;
    asub = 1'b0;
    acin = 1'b0;
    case (op_sel)
      OP_ADC: acin = flags_q[FC];
      OP_SUB,
      OP_CMP: asub = 1'b1;
      OP_SBC: begin asub = 1'b1; acin = flags_q[FC]; end
      OP_NEG: begin ax = '0; ay = opnd_a; asub = 1'b1; end
      OP_INC: ay = W'(1);
      OP_DEC: begin ay = W'(1); asub = 1'b1; end
      default: ;
    endcase
    case (op_sel)
      OP_AND:  lfn = 2'd0;
      OP_OR:   lfn = 2'd1;
      default: lfn = 2'd2;
    endcase
  end

  alu8_addsub #(.W(W)) u_add (
    .x(ax), .y(ay), .sub(asub), .cin(acin),
    .r(ar), .cy(acy), .hc(ahc), .ov(aov)
  );

  alu8_logic #(.W(W)) u_log (
    .x(opnd_a), .y(opnd_b), .fn(lfn), .r(lr), .even(leven)
  );

  // Per-operation flag rules; untouched flags keep the held value.
  always_comb begin
    nf     = flags_q;
    result = opnd_a;
    case (op_sel)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
        if (op_sel != OP_CMP) result = ar;
        nf[FC] = acy;
        nf[FH] = ahc;
        nf[FP] = aov;
        nf[FN] = asub;
        nf[FZ] = (ar == '0);
        nf[FS] = ar[W-1];
      end
      OP_INC, OP_DEC: begin
        result = ar;
        nf[FH] = ahc;
        nf[FP] = aov;
        nf[FN] = asub;
        nf[FZ] = (ar == '0);
        nf[FS] = ar[W-1];
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = lr;
        nf[FC] = 1'b0;
        nf[FN] = 1'b0;
        nf[FH] = (op_sel == OP_AND);
        nf[FP] = leven;
        nf[FZ] = (lr == '0);
        nf[FS] = lr[W-1];
      end
      OP_CPL: begin
        result = ~opnd_a;
        nf[FH] = 1'b1;
        nf[FN] = 1'b1;
      end
      OP_SCF: begin nf[FC] = 1'b1;           nf[FN] = 1'b0; end
      OP_CCF: begin nf[FC] = ~flags_q[FC];   nf[FN] = 1'b0; end
      default: ;
    endcase
  end

  assign flags_nxt = nf;

  alu8_flagreg #(.NF(NFLAG)) u_freg (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .d(nf), .q(flags_q)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_sel,
  input logic [W-1:0]     opnd_a,
  input logic             flag_we,
  input logic [W-1:0]     result,
  input logic [NFLAG-1:0] flags_nxt,
  input logic [NFLAG-1:0] flags_q
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags_q == $past(flags_nxt)));

  assert_logic_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)
      |-> (!flags_nxt[FC] && !flags_nxt[FN]));

  assert_sub_sets_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SUB || op_sel == OP_SBC || op_sel == OP_CMP ||
     op_sel == OP_NEG || op_sel == OP_DEC) |-> flags_nxt[FN]);

  assert_incdec_keep_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_INC || op_sel == OP_DEC) |-> (flags_nxt[FC] == flags_q[FC]));

  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP) |-> (result == opnd_a));

  assert_cpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CPL) |-> (result == ~opnd_a && flags_nxt[FH] && flags_nxt[FN]));

  assert_spare_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_RS0 || op_sel == OP_RS1) |-> (flags_nxt == flags_q && result == opnd_a));
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
  .flag_we(flag_we), .result(result), .flags_nxt(flags_nxt), .flags_q(flags_q)
);

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_sel;
  logic [7:0] opnd_a, opnd_b;
  logic       flag_we;
  logic [7:0] result;
  logic [5:0] flags_nxt, flags_q;

  int errors = 0;
  int checks = 0;
  logic [5:0] exp_f;

  always #10 clk = ~clk;  // 50 MHz

  alu8_flags i_alu8_flags (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flag_we(flag_we), .result(result), .flags_nxt(flags_nxt), .flags_q(flags_q)
  );

  function automatic int sx(input logic [7:0] v);
    return (v > 8'd127) ? int'(v) - 256 : int'(v);
  endfunction

  // Reference model: returns {flags, result}. Flag bits: 0 C, 1 N, 2 P/V, 3 H, 4 Z, 5 S.
  function automatic logic [13:0] ref_alu(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [5:0] f);
    logic [5:0] n = f;
    logic [7:0] r = a;
    int x, y, ci, s, lo, sv;
    bit arith = 1'b0, is_sub = 1'b0, keep_c = 1'b0, wr = 1'b1;
    x = int'(a); y = int'(b); ci = 0;
    case (op)
      4'd0: arith = 1;
      4'd1: begin arith = 1; ci = int'(f[0]); end
      4'd2: begin arith = 1; is_sub = 1; end
      4'd3: begin arith = 1; is_sub = 1; ci = int'(f[0]); end
      4'd4: begin arith = 1; is_sub = 1; wr = 0; end
      4'd5: begin arith = 1; is_sub = 1; x = 0; y = int'(a); end
      4'd9: begin arith = 1; y = 1; keep_c = 1; end
      4'd10: begin arith = 1; is_sub = 1; y = 1; keep_c = 1; end
      default: ;
    endcase
    if (arith) begin
      if (is_sub) begin
        s = x - y - ci; lo = (x % 16) - (y % 16) - ci;
        sv = sx(8'(x)) - sx(8'(y)) - ci;
      end else begin
        s = x + y + ci; lo = (x % 16) + (y % 16) + ci;
        sv = sx(8'(x)) + sx(8'(y)) + ci;
      end
      if (!keep_c) n[0] = is_sub ? (s < 0) : (s > 255);
      n[3] = is_sub ? (lo < 0) : (lo > 15);
      n[2] = (sv > 127) || (sv < -128);
      n[1] = is_sub;
      n[4] = (8'(s) == 8'd0);
      n[5] = s[7];
      if (wr) r = 8'(s);
    end else begin
      case (op)
        4'd6, 4'd7, 4'd8: begin
          r = (op == 4'd6) ? (a & b) : (op == 4'd7) ? (a | b) : (a ^ b);
          n[0] = 0; n[1] = 0; n[3] = (op == 4'd6);
          n[2] = ($countones(r) % 2) == 0;
          n[4] = (r == 8'd0); n[5] = r[7];
        end
        4'd11: begin r = ~a; n[3] = 1; n[1] = 1; end
        4'd12: begin n[0] = 1; n[1] = 0; end
        4'd13: begin n[0] = ~f[0]; n[1] = 0; end
        default: ;
      endcase
    end
    return {n, r};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4: return "R3";
      4'd5: return "R4";
      4'd6, 4'd7, 4'd8: return "R5";
      4'd9, 4'd10: return "R6";
      4'd11: return "R8";
      4'd12, 4'd13: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic we);
    logic [13:0] e;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; flag_we = we;
    #2;
    e = ref_alu(op, a, b, exp_f);
    check(tag_of(op), "result", result, e[7:0]);
    check(tag_of(op), "flags_nxt", {2'b00, flags_nxt}, {2'b00, e[13:8]});
    if (op <= 4'd10) check("R7", "zero/sign", {6'd0, flags_nxt[5:4]}, {6'd0, e[13:12]});
    @(posedge clk);
    #2;
    if (we) exp_f = e[13:8];
    check("R10", "flags_q", {2'b00, flags_q}, {2'b00, exp_f});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0; flag_we = 1'b0;
    exp_f = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R10", "reset flags_q", {2'b00, flags_q}, 8'h00);

    // Directed corner cases
    step(4'd0, 8'h7F, 8'h01, 1'b1);  // signed overflow, half carry
    step(4'd0, 8'hFF, 8'h01, 1'b1);  // carry out, zero result
    step(4'd1, 8'h10, 8'h0F, 1'b1);  // carry-in taken from held C
    step(4'd2, 8'h80, 8'h01, 1'b1);  // signed overflow on subtract
    step(4'd2, 8'h05, 8'h05, 1'b1);  // zero result
    step(4'd2, 8'h00, 8'h01, 1'b1);  // borrow
    step(4'd3, 8'h10, 8'h00, 1'b1);  // borrow-in from held C
    step(4'd4, 8'h40, 8'h41, 1'b1);  // compare keeps result
    step(4'd5, 8'h80, 8'h00, 1'b1);  // negate most negative value
    step(4'd5, 8'h00, 8'h00, 1'b1);  // negate zero
    step(4'd6, 8'hF0, 8'h3C, 1'b1);  // AND, even parity
    step(4'd7, 8'h01, 8'h02, 1'b1);  // OR, even parity
    step(4'd8, 8'h07, 8'h00, 1'b1);  // XOR, odd parity
    step(4'd12, 8'h00, 8'h00, 1'b1); // set carry
    step(4'd9, 8'h7F, 8'h00, 1'b1);  // increment overflow, keeps C
    step(4'd10, 8'h80, 8'h00, 1'b1); // decrement overflow
    step(4'd9, 8'hFF, 8'h00, 1'b1);  // increment wraps to zero
    step(4'd11, 8'hA5, 8'h00, 1'b1); // complement
    step(4'd13, 8'h00, 8'h00, 1'b1); // complement carry
    step(4'd13, 8'h00, 8'h00, 1'b1);
    step(4'd14, 8'h33, 8'h44, 1'b1); // spare codes
    step(4'd15, 8'hCC, 8'h11, 1'b1);
    step(4'd0, 8'hFF, 8'hFF, 1'b0);  // hold with strobe low

    for (int i = 0; i < 3000; i++) begin
      step(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), ($urandom_range(0, 3) != 0));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule